// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a single-port synchronous memory whose word is split into two byte lanes. The default lane width is 9 bits, which gives an 18-bit word. With a lane width of 8 the word is 16 bits. The rising edge of one clock captures every input: address, write data, the three chip selects and the write controls.

A read takes one more register stage on the way out, so the device behaves as a pipelined part. A write needs no external strobe. The memory array takes the captured data on the edge after the capture edge.

Write qualification has two levels:
- A whole-word write input forces both lanes to be written.
- Without it, a lane-write enable allows each lane's own select to pick that lane.

The three chip selects allow several instances to be stacked in depth. A cycle counts only when all three selects are active.

Top module: `pipe_sram`

## Requirements
- R1: After a clock edge with `rst_n` low, `dout` is zero. A read captured while `rst_n` was low does not load `dout` afterwards.
- R2: A cycle is accepted only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination writes nothing and leaves `dout` unchanged.
- R3: A read presented before clock edge k appears on `dout` after edge k+1. Reads issued on consecutive cycles return their data on consecutive cycles.
- R4: With `all_wr_n`=0 the cycle writes both lanes, whatever the values of `lane_wr_en_n` and `lane_sel_n`.
- R5: With `all_wr_n`=1 and `lane_wr_en_n`=0, lane i is written exactly when `lane_sel_n[i]`=0. Lane 0 is `din[LANE_W-1:0]` and lane 1 is `din[2*LANE_W-1:LANE_W]`. A lane that is not written keeps its old contents.
- R6: With `all_wr_n`=1 and `lane_wr_en_n`=1 the cycle is a read, and `lane_sel_n` has no effect.
- R7: Write cycles, including a lane-enabled write with both lane selects high (which writes no lane), do not change `dout`.
- R8: With LANE_W=9, the ninth bit of each lane (bits 8 and 17) is stored and returned with its lane.
- R9: A read captured one cycle after a write to the same address returns the new data. A read captured one cycle before a write to the same address returns the old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is captured on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Whole-word write, active low, overrides the lane controls |
| lane_wr_en_n | input | 1 | Enables the per-lane selects, active low |
| lane_sel_n | input | 2 | Per-lane write select, active low; bit i is lane i |
| addr | input | ADDR_W | Word address |
| din | input | 2*LANE_W | Write data |
| dout | output | 2*LANE_W | Registered read data |

## Verification
The case that is hardest to reach from the ports is a read and a write to the same word in adjacent cycles. The answer depends on which one the input register captured first. The stimulus issues a write and then a read of the same address in back-to-back cycles, and also a read and then a write. The expected word is taken from a shadow model that is updated in issue order. A second corner is a read that is captured while reset is low: reset is released in the very next cycle, and the output must stay at zero.

// File: rtl/sram_pkg.sv
// Package: shared lane count, lane mask type and write-control decoding.
// Assumes the two-lane word organisation used by every module of the memory.
package sram_pkg;
    localparam int LANES = 2;

    typedef logic [LANES-1:0] lane_mask_t;

    // Lanes to be written: whole-word write wins, otherwise enabled lane selects.
    function automatic lane_mask_t lane_select(input logic all_wr_n,
                                               input logic lane_wr_en_n,
                                               input lane_mask_t lane_sel_n);
        if (!all_wr_n)
            return '1;
        else if (!lane_wr_en_n)
            return ~lane_sel_n;
        else
            return '0;
    endfunction

    // A cycle is a write cycle when either write control is asserted.
    function automatic logic is_write(input logic all_wr_n, input logic lane_wr_en_n);
        return !(all_wr_n && lane_wr_en_n);
    endfunction
endpackage

// File: rtl/sram_in_reg.sv
// Input stage: captures select, write controls, address and data on the
// rising edge and turns them into a per-lane write mask.
// Assumes synchronous active-low reset; the address and data paths are not reset.
module sram_in_reg
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_en_n,
    input  lane_mask_t        lane_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              sel_q,
    output logic              wr_q,
    output lane_mask_t        lanes_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);
    logic selected;

    // All three chip selects must be active for the cycle to count.
    always_comb selected = !cs0_n && cs1 && !cs2_n;

    // Control register: cleared in reset so no stale cycle survives it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
            lanes_q <= '0;
        end else begin
            sel_q   <= selected;
            wr_q    <= is_write(all_wr_n, lane_wr_en_n);
            lanes_q <= selected ? lane_select(all_wr_n, lane_wr_en_n, lane_sel_n) : '0;
        end
    end

    // Datapath register: address and write data follow the inputs every edge.
    always_ff @(posedge clk) begin
        addr_q <= addr;
        din_q  <= din;
    end

    // R4: a selected whole-word write marks both lanes.
    a_r4_whole_word: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !all_wr_n) |=> (sel_q && wr_q && lanes_q == '1));

    // R2: a deselected cycle leaves no accepted cycle and no lane write.
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected) |=> (!sel_q && lanes_q == '0));

    // R6: a read cycle never marks a lane, whatever the lane selects are.
    a_r6_read_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && all_wr_n && lane_wr_en_n) |=> (!wr_q && lanes_q == '0));
endmodule

// File: rtl/sram_array.sv
// Storage: one array per byte lane, each written only when its lane bit is set.
// Assumes the write mask is already qualified by select; the read is asynchronous
// and the result is registered by the output stage.
module sram_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  lane_mask_t              we_lanes,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write: store this lane's slice when its mask bit is set.
        always_ff @(posedge clk) begin
            if (we_lanes[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Lane read: present the addressed word to the output stage.
        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/sram_out_reg.sv
// Output stage: holds the last read word and loads only on accepted reads.
// Assumes synchronous active-low reset that clears the output to zero.
module sram_out_reg #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Output register: cleared in reset, otherwise loaded on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R1: an edge in reset leaves the output at zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        (!rst_n) |=> (q == '0));

    // R7: without a load the output stays put.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> $stable(q));
endmodule

// File: rtl/pipe_sram.sv
// Top: input register, lane-split storage and output register in a
// two-edge read pipeline. Writes reach the array one edge after capture,
// so ordering between adjacent reads and writes needs no bypass.
module pipe_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [1:0]              lane_sel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2*LANE_W-1:0]     din,
    output logic [2*LANE_W-1:0]     dout
);
    localparam int DATA_W = LANES * LANE_W;

    logic              sel_q;
    logic              wr_q;
    lane_mask_t        lanes_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] rdata;
    logic              rd_load;

    sram_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs0_n        (cs0_n),
        .cs1          (cs1),
        .cs2_n        (cs2_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .addr         (addr),
        .din          (din),
        .sel_q        (sel_q),
        .wr_q         (wr_q),
        .lanes_q      (lanes_q),
        .addr_q       (addr_q),
        .din_q        (din_q)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .we_lanes (lanes_q),
        .addr     (addr_q),
        .wdata    (din_q),
        .rdata    (rdata)
    );

    // Read qualification: only an accepted non-write cycle loads the output.
    always_comb rd_load = sel_q && !wr_q;

    sram_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .d     (rdata),
        .q     (dout)
    );

    // R3: the word seen on the read path lands on the output one edge later.
    a_r3_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !wr_q) |=> (dout == $past(rdata)));
endmodule

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;
    localparam int AW = 8;
    localparam int LW = 9;
    localparam int DW = 2 * LW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          cs0_n, cs1, cs2_n;
    logic          all_wr_n, lane_wr_en_n;
    logic [1:0]    lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] model [0:(1<<AW)-1];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic rd_flag = 1'b0;
    logic due1 = 1'b0;
    logic due2 = 1'b0;
    logic [DW-1:0] held;

    pipe_sram #(.ADDR_W(AW), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .addr(addr), .din(din), .dout(dout)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Driver: applies one cycle, updates the shadow model and queues expected reads.
    task automatic op(input logic c0n, input logic c1, input logic c2n,
                      input logic aw, input logic le, input logic [1:0] ls,
                      input int a, input logic [DW-1:0] d, input string tag);
        logic sel;
        cs0_n = c0n; cs1 = c1; cs2_n = c2n;
        all_wr_n = aw; lane_wr_en_n = le; lane_sel_n = ls;
        addr = a[AW-1:0]; din = d;
        sel = !c0n && c1 && !c2n;
        rd_flag = sel && aw && le;
        if (rd_flag) begin
            exp_q.push_back(model[a]);
            tag_q.push_back(tag);
        end
        if (sel && !(aw && le)) begin
            for (int l = 0; l < 2; l++)
                if (!aw || (!le && !ls[l]))
                    model[a][l*LW +: LW] = d[l*LW +: LW];
        end
        @(negedge clk);
    endtask

    task automatic wr_all(input int a, input logic [DW-1:0] d);
        op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, a, d, "write");
    endtask
    task automatic wr_lane(input int a, input logic [1:0] ls, input logic [DW-1:0] d);
        op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ls, a, d, "lane write");
    endtask
    task automatic rd(input int a, input logic [1:0] ls, input string tag);
        op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, ls, a, '0, tag);
    endtask
    task automatic idle();
        op(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 0, '0, "idle");
    endtask

    // Monitor pipeline: a read sampled at edge k is compared after edge k+1.
    always @(posedge clk) begin
        if (!rst_n) begin
            due1 <= 1'b0;
            due2 <= 1'b0;
        end else begin
            due1 <= rd_flag;
            due2 <= due1;
        end
    end

    always @(negedge clk) begin
        if (due2) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R3: read result with nothing expected, actual=%h expected=none", dout);
            end else begin
                chk(tag_q.pop_front(), dout, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset output", dout, '0);
        rst_n = 1'b1;

        // R4: whole-word writes, with and without the lane controls asserted.
        wr_all(5, 18'h2A5A5);
        op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 6, 18'h1C3F0, "write");
        op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 7, 18'h3FFFF, "write");
        rd(5, 2'b11, "R4 whole word, lanes idle");
        rd(6, 2'b11, "R4 whole word, lane selects high");
        rd(7, 2'b11, "R4 whole word, one lane select");

        // R5 / R8: single-lane writes keep the other lane, ninth bits included.
        wr_all(10, 18'h3FFFF);
        wr_lane(10, 2'b10, 18'h00100);
        rd(10, 2'b11, "R5 R8 lane 0 only");
        wr_all(11, 18'h00000);
        wr_lane(11, 2'b01, 18'h20000);
        rd(11, 2'b11, "R5 R8 lane 1 only");
        wr_lane(12, 2'b00, 18'h20100);
        rd(12, 2'b11, "R5 R8 both lanes");

        // R6: the lane selects have no effect on a read.
        rd(10, 2'b00, "R6 read, selects low");
        rd(10, 2'b01, "R6 read, one select low");

        // R2: a write with any single chip select inactive is dropped.
        op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 5, 18'h11111, "deselected");
        op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 5, 18'h22222, "deselected");
        op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 5, 18'h33333, "deselected");
        rd(5, 2'b11, "R2 deselected writes dropped");

        // R7: write cycles, including one that writes no lane, leave dout alone.
        wr_all(30, 18'h15555);
        wr_all(31, 18'h0ABCD);
        rd(30, 2'b11, "R7 setup read");
        held = model[30];
        wr_lane(31, 2'b11, 18'h3FFFF);
        wr_all(30, 18'h01234);
        idle();
        chk("R7 dout held through writes", dout, held);
        // R2: deselected reads leave dout alone.
        op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 31, '0, "deselected read");
        op(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 31, '0, "deselected read");
        idle();
        chk("R2 dout held on deselected reads", dout, held);
        rd(31, 2'b11, "R7 no-lane write kept old word");
        rd(30, 2'b11, "R7 later write landed");

        // R9: adjacent write/read ordering on one address.
        wr_all(20, 18'h00F0F);
        wr_all(20, 18'h3C3C3);
        rd(20, 2'b11, "R9 read right after write");
        wr_all(21, 18'h12345);
        idle();
        rd(21, 2'b11, "R9 read right before write");
        wr_all(21, 18'h2FEDC);
        rd(21, 2'b11, "R9 write then visible");

        // R3: back-to-back reads return on consecutive cycles.
        rd(5, 2'b11, "R3 burst 0");
        rd(6, 2'b11, "R3 burst 1");
        rd(10, 2'b11, "R3 burst 2");
        rd(12, 2'b11, "R3 burst 3");
        repeat (3) idle();
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R3: pending reads actual=%0d expected=0", exp_q.size());
        end

        // R1: a read captured in reset must not load dout after reset ends.
        chk("R1 dout nonzero before reset", (dout != '0) ? 18'h1 : 18'h0, 18'h1);
        cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; addr = 8'd5; rd_flag = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears dout", dout, '0);
        rst_n = 1'b1;
        idle();
        chk("R1 read captured in reset dropped", dout, '0);
        rd(7, 2'b11, "R1 read after reset");
        repeat (2) idle();

        summary();
        $finish;
    end
endmodule